// File: doc/BRIEF.md
# Two-Bank Level Interrupt Aggregator

This block gathers sixty-four level-sensitive peripheral interrupt lines and eight level-sensitive core-local lines into two processor requests: a normal interrupt request (IRQ) and a fast interrupt request (FIQ). Each source has an enable bit. Software turns enable bits on through set-only registers and turns them off through clear-only registers, so it never needs a read-modify-write sequence. Software reads which enabled sources are active through two bank pending words and a summary word. The summary word combines the core sources, a nonzero flag for each peripheral bank and eleven frequently used peripheral sources, so one read is often enough to find the cause.

A separate FIQ route sends exactly one raw source to the FIQ output. A 7-bit index that spans both banks picks the source, and the enable masks do not gate it. Both outputs are combinational functions of the input levels and the registered control state. The register port is a simple strobe interface with 32-bit words. A read returns its data one clock after the read strobe.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, both peripheral enable words, the core enable mask, the FIQ enable and the FIQ index are all zero. With every input line high, IRQ and FIQ stay low.
- R2: A write to 0x10 (low bank, sources 0 to 31) or 0x14 (high bank, sources 32 to 63) ORs the written word into that enable word. A read of the same offset returns the enable word.
- R3: A write to 0x1C or 0x20 clears each bit of the low or high enable word where the written word holds a 1. A read of 0x1C or 0x20 returns the bitwise inverse of that enable word.
- R4: Writes to 0x18 (set) and 0x24 (clear) act on the 8-bit core enable mask using only data bits 7:0. A read of 0x18 returns the mask zero-extended. A read of 0x24 returns the full 32-bit inverse of that zero-extended value, so bits 31:8 read as 1.
- R5: A read of 0x04 returns (level AND enable) for peripheral sources 0 to 31, with source n in bit n. A read of 0x08 does the same for sources 32 to 63, with source n in bit n−32.
- R6: A read of 0x00 returns the summary word:
  - bits 7:0 hold the masked core sources;
  - bit 8 is the OR of masked sources 0 to 31;
  - bit 9 is the OR of masked sources 32 to 63;
  - bits 10 through 20 hold the masked peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order;
  - bits 31:21 are 0.
- R7: A write to 0x0C loads the FIQ index from data bits 6:0 and the FIQ enable from bit 7. A read of 0x0C returns the enable in bit 7, the index in bits 6:0, and zeros in the upper bits.
- R8: While the FIQ enable is 1, FIQ follows the raw level of the selected source, whatever the enable masks hold. Index 0 to 63 selects that peripheral source, index 64 to 71 selects core source (index−64), and index 72 to 127 selects nothing, so FIQ is 0. While the FIQ enable is 0, FIQ is 0.
- R9: IRQ is 1 exactly when at least one source, peripheral or core, is both high and enabled.
- R10: A read of any offset other than the ten listed offsets returns 0. An unaligned offset (bits 1:0 not zero) counts as unlisted. Writes to unlisted offsets and to the pending offsets 0x00, 0x04 and 0x08 change no state.
- R11: A change of an input level shows on IRQ and FIQ in the same cycle. A register write shows on them right after the clock edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| periph_lvl | input | 64 | Peripheral interrupt levels, one bit per source |
| core_lvl | input | 8 | Core-local interrupt levels |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | ADDR_W (9) | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en; holds until the next read |
| irq_o | output | 1 | Interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest condition to reach from the ports is a source that is raised but not enabled while it is also the FIQ selection. This case separates the unmasked FIQ path from the masked IRQ and pending paths. The stimulus builds it on purpose: it enables a single far-away source, points the FIQ index at a different source whose enable bit is 0, and toggles that line. FIQ must follow the line while IRQ and the pending words stay quiet. The index boundaries 63, 64 to 71 and the dead range from 72 upward are each reached by a direct write to the FIQ control word. The duplicated bits of the summary word are reached by single-source patterns and by clearing one enable bit inside the high bank.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int PERIPH_N = 64;
  localparam int CORE_N   = 8;
  localparam int WORD_W   = 32;
  localparam int BANKS    = PERIPH_N / WORD_W;
  localparam int DUP_N    = 11;
  localparam int SEL_W    = 7;
  localparam int PIDX_W   = $clog2(PERIPH_N);
  localparam int CIDX_W   = $clog2(CORE_N);
  localparam int SUM_USED = CORE_N + BANKS + DUP_N;

  typedef enum logic [3:0] {
    RS_SUMMARY,
    RS_PEND_LO,
    RS_PEND_HI,
    RS_FIQ_CTL,
    RS_SET_LO,
    RS_SET_HI,
    RS_SET_CORE,
    RS_CLR_LO,
    RS_CLR_HI,
    RS_CLR_CORE,
    RS_NONE
  } reg_sel_e;

  // Map a byte offset onto the register it names.
  function automatic reg_sel_e decode_offset(input logic [31:0] off);
    reg_sel_e r;
    if (off[1:0] != 2'b00) begin
      r = RS_NONE;
    end else begin
      case (off)
        32'h00:  r = RS_SUMMARY;
        32'h04:  r = RS_PEND_LO;
        32'h08:  r = RS_PEND_HI;
        32'h0C:  r = RS_FIQ_CTL;
        32'h10:  r = RS_SET_LO;
        32'h14:  r = RS_SET_HI;
        32'h18:  r = RS_SET_CORE;
        32'h1C:  r = RS_CLR_LO;
        32'h20:  r = RS_CLR_HI;
        32'h24:  r = RS_CLR_CORE;
        default: r = RS_NONE;
      endcase
    end
    return r;
  endfunction

  // Peripheral source copied into summary slot k.
  function automatic int dup_source(input int k);
    int s;
    case (k)
      0:       s = 7;
      1:       s = 9;
      2:       s = 10;
      3:       s = 18;
      4:       s = 19;
      5:       s = 53;
      6:       s = 54;
      7:       s = 55;
      8:       s = 56;
      9:       s = 57;
      default: s = 62;
    endcase
    return s;
  endfunction

  function automatic logic [DUP_N-1:0] pick_dups(input logic [PERIPH_N-1:0] pend);
    logic [DUP_N-1:0] d;
    for (int k = 0; k < DUP_N; k++) begin
      d[k] = pend[dup_source(k)];
    end
    return d;
  endfunction

  // Raw level of the source named by a FIQ index; out-of-range picks nothing.
  function automatic logic fiq_pick(input logic [PERIPH_N-1:0] p,
                                    input logic [CORE_N-1:0]   c,
                                    input logic [SEL_W-1:0]    sel);
    logic v;
    if (int'(sel) < PERIPH_N) begin
      v = p[sel[PIDX_W-1:0]];
    end else if (int'(sel) < PERIPH_N + CORE_N) begin
      v = c[sel[CIDX_W-1:0]];
    end else begin
      v = 1'b0;
    end
    return v;
  endfunction

endpackage

// File: rtl/irqagg_regs.sv
module irqagg_regs
  import irqagg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  reg_sel_e             sel,
  input  logic [WORD_W-1:0]    wdata,
  output logic [PERIPH_N-1:0]  pmask,
  output logic [CORE_N-1:0]    cmask,
  output logic                 fiq_en,
  output logic [SEL_W-1:0]     fiq_idx
);

  // One set/clear enable word per peripheral bank.
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam reg_sel_e SET_SEL = (b == 0) ? RS_SET_LO : RS_SET_HI;
    localparam reg_sel_e CLR_SEL = (b == 0) ? RS_CLR_LO : RS_CLR_HI;
    logic set_hit;
    logic clr_hit;
    assign set_hit = wr_stb && (sel == SET_SEL);
    assign clr_hit = wr_stb && (sel == CLR_SEL);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pmask[b*WORD_W +: WORD_W] <= '0;
      end else if (set_hit) begin
        pmask[b*WORD_W +: WORD_W] <= pmask[b*WORD_W +: WORD_W] | wdata;
      end else if (clr_hit) begin
        pmask[b*WORD_W +: WORD_W] <= pmask[b*WORD_W +: WORD_W] & ~wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmask <= '0;
    end else if (wr_stb && sel == RS_SET_CORE) begin
      cmask <= cmask | wdata[CORE_N-1:0];
    end else if (wr_stb && sel == RS_CLR_CORE) begin
      cmask <= cmask & ~wdata[CORE_N-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_en  <= 1'b0;
      fiq_idx <= '0;
    end else if (wr_stb && sel == RS_FIQ_CTL) begin
      fiq_en  <= wdata[SEL_W];
      fiq_idx <= wdata[SEL_W-1:0];
    end
  end

endmodule

// File: rtl/irqagg_pend.sv
module irqagg_pend
  import irqagg_pkg::*;
(
  input  logic [PERIPH_N-1:0] periph_lvl,
  input  logic [CORE_N-1:0]   core_lvl,
  input  logic [PERIPH_N-1:0] pmask,
  input  logic [CORE_N-1:0]   cmask,
  output logic [PERIPH_N-1:0] pend_p,
  output logic [CORE_N-1:0]   pend_c,
  output logic [WORD_W-1:0]   summary,
  output logic                irq_any
);

  logic [BANKS-1:0] bank_any;
  logic [DUP_N-1:0] dups;

  assign pend_p = periph_lvl & pmask;
  assign pend_c = core_lvl & cmask;

  for (genvar b = 0; b < BANKS; b++) begin : g_any
    assign bank_any[b] = |pend_p[b*WORD_W +: WORD_W];
  end

  assign dups    = pick_dups(pend_p);
  assign summary = {{(WORD_W-SUM_USED){1'b0}}, dups, bank_any, pend_c};
  assign irq_any = (|bank_any) || (|pend_c);

endmodule

// File: rtl/irqagg_fiq.sv
module irqagg_fiq
  import irqagg_pkg::*;
(
  input  logic [PERIPH_N-1:0] periph_lvl,
  input  logic [CORE_N-1:0]   core_lvl,
  input  logic                fiq_en,
  input  logic [SEL_W-1:0]    fiq_idx,
  output logic                fiq
);

  logic picked;
  assign picked = fiq_pick(periph_lvl, core_lvl, fiq_idx);
  assign fiq    = fiq_en && picked;

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [PERIPH_N-1:0] periph_lvl,
  input  logic [CORE_N-1:0]   core_lvl,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic                irq_o,
  output logic                fiq_o
);

  reg_sel_e              sel_w;
  logic [PERIPH_N-1:0]   pmask_w;
  logic [CORE_N-1:0]     cmask_w;
  logic                  fiq_en_w;
  logic [SEL_W-1:0]      fiq_idx_w;
  logic [PERIPH_N-1:0]   pend_p_w;
  logic [CORE_N-1:0]     pend_c_w;
  logic [WORD_W-1:0]     summary_w;
  logic                  irq_any_w;
  logic                  fiq_w;
  logic [WORD_W-1:0]     rd_next;

  assign sel_w = decode_offset(32'(addr));

  irqagg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_en),
    .sel     (sel_w),
    .wdata   (wdata),
    .pmask   (pmask_w),
    .cmask   (cmask_w),
    .fiq_en  (fiq_en_w),
    .fiq_idx (fiq_idx_w)
  );

  irqagg_pend u_pend (
    .periph_lvl (periph_lvl),
    .core_lvl   (core_lvl),
    .pmask      (pmask_w),
    .cmask      (cmask_w),
    .pend_p     (pend_p_w),
    .pend_c     (pend_c_w),
    .summary    (summary_w),
    .irq_any    (irq_any_w)
  );

  irqagg_fiq u_fiq (
    .periph_lvl (periph_lvl),
    .core_lvl   (core_lvl),
    .fiq_en     (fiq_en_w),
    .fiq_idx    (fiq_idx_w),
    .fiq        (fiq_w)
  );

  always_comb begin
    case (sel_w)
      RS_SUMMARY:  rd_next = summary_w;
      RS_PEND_LO:  rd_next = pend_p_w[WORD_W-1:0];
      RS_PEND_HI:  rd_next = pend_p_w[PERIPH_N-1:WORD_W];
      RS_FIQ_CTL:  rd_next = {{(WORD_W-SEL_W-1){1'b0}}, fiq_en_w, fiq_idx_w};
      RS_SET_LO:   rd_next = pmask_w[WORD_W-1:0];
      RS_SET_HI:   rd_next = pmask_w[PERIPH_N-1:WORD_W];
      RS_SET_CORE: rd_next = {{(WORD_W-CORE_N){1'b0}}, cmask_w};
      RS_CLR_LO:   rd_next = ~pmask_w[WORD_W-1:0];
      RS_CLR_HI:   rd_next = ~pmask_w[PERIPH_N-1:WORD_W];
      RS_CLR_CORE: rd_next = ~{{(WORD_W-CORE_N){1'b0}}, cmask_w};
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_next;
    end
  end

  assign irq_o = irq_any_w;
  assign fiq_o = fiq_w;

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [WORD_W-1:0]   wdata,
  input logic [PERIPH_N-1:0] periph_lvl,
  input logic [CORE_N-1:0]   core_lvl,
  input logic [PERIPH_N-1:0] pmask,
  input logic [CORE_N-1:0]   cmask,
  input logic                fiq_en,
  input logic [SEL_W-1:0]    fiq_idx,
  input logic                irq_o,
  input logic                fiq_o
);

  localparam logic [ADDR_W-1:0] A_FIQ    = ADDR_W'(32'h0C);
  localparam logic [ADDR_W-1:0] A_SET_LO = ADDR_W'(32'h10);
  localparam logic [ADDR_W-1:0] A_CLR_HI = ADDR_W'(32'h20);
  localparam logic [ADDR_W-1:0] A_CLR_C  = ADDR_W'(32'h24);

  logic unlisted_wr;
  assign unlisted_wr = wr_en && ((addr[1:0] != 2'b00) || (addr < A_FIQ) || (addr > A_CLR_C));

  // R2
  a_r2_set_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_SET_LO) |=> ((pmask[WORD_W-1:0] & $past(wdata)) == $past(wdata)));

  // R3
  a_r3_clear_drops_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR_HI) |=> ((pmask[PERIPH_N-1:WORD_W] & $past(wdata)) == '0));

  // R4
  a_r4_core_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CLR_C) |=> ((cmask & $past(wdata[CORE_N-1:0])) == '0));

  // R7
  a_r7_fiq_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FIQ) |=> (fiq_idx == $past(wdata[SEL_W-1:0]) && fiq_en == $past(wdata[SEL_W])));

  // R8
  a_r8_fiq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_en |-> !fiq_o);

  // R8
  a_r8_dead_index: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_en && int'(fiq_idx) >= PERIPH_N + CORE_N) |-> !fiq_o);

  // R8
  a_r8_fiq_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ((|periph_lvl) || (|core_lvl)));

  // R9
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|pmask) || (|cmask)));

  // R10
  a_r10_unlisted_write: assert property (@(posedge clk) disable iff (!rst_n)
    unlisted_wr |=> ($stable(pmask) && $stable(cmask) && $stable(fiq_en) && $stable(fiq_idx)));

endmodule

bind irq_aggregator irqagg_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .wdata      (wdata),
  .periph_lvl (periph_lvl),
  .core_lvl   (core_lvl),
  .pmask      (pmask_w),
  .cmask      (cmask_w),
  .fiq_en     (fiq_en_w),
  .fiq_idx    (fiq_idx_w),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o)
);

// File: tb/irq_aggregator_tb.sv
`timescale 1ns/1ps
module irq_aggregator_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] periph_lvl = '0;
  logic [7:0]  core_lvl = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o;
  logic        fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .periph_lvl(periph_lvl), .core_lvl(core_lvl),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_check(input string tag, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, exp);
  endtask

  // Summary word rebuilt from the requirement text.
  function automatic logic [31:0] summary_model(input logic [63:0] pp, input logic [7:0] pc);
    int list [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
    logic [31:0] s;
    s = {24'h0, pc};
    s[8] = (pp[31:0] != 0);
    s[9] = (pp[63:32] != 0);
    foreach (list[i]) s[10 + i] = pp[list[i]];
    return s;
  endfunction

  task automatic t_reset;
    periph_lvl = '1; core_lvl = '1;
    #1;
    check("R1 irq after reset", 32'(irq_o), 32'h0);
    check("R1 fiq after reset", 32'(fiq_o), 32'h0);
    rd_check("R1 low enables", 9'h10, 32'h0);
    rd_check("R1 high enables", 9'h14, 32'h0);
    rd_check("R1 core enables", 9'h18, 32'h0);
    rd_check("R1 fiq control", 9'h0C, 32'h0);
    periph_lvl = '0; core_lvl = '0;
  endtask

  task automatic t_set;
    wr(9'h10, 32'h0000_00F0);
    wr(9'h10, 32'h0000_0F00);
    rd_check("R2 low set accumulates", 9'h10, 32'h0000_0FF0);
    wr(9'h14, 32'h8000_0001);
    rd_check("R2 high set", 9'h14, 32'h8000_0001);
  endtask

  task automatic t_clear;
    wr(9'h1C, 32'h0000_0030);
    rd_check("R3 low clear", 9'h10, 32'h0000_0FC0);
    rd_check("R3 low clear reads inverse", 9'h1C, 32'hFFFF_F03F);
    wr(9'h20, 32'hFFFF_FFFF);
    rd_check("R3 high clear all", 9'h14, 32'h0);
    rd_check("R3 high inverse", 9'h20, 32'hFFFF_FFFF);
  endtask

  task automatic t_core;
    wr(9'h18, 32'hFFFF_FF5A);
    rd_check("R4 core set low byte only", 9'h18, 32'h0000_005A);
    rd_check("R4 core inverse", 9'h24, 32'hFFFF_FFA5);
    wr(9'h24, 32'h0000_0102);
    rd_check("R4 core clear", 9'h18, 32'h0000_0058);
  endtask

  task automatic t_pending;
    wr(9'h14, 32'hFFFF_0000);
    periph_lvl = 64'hAAAA_5555_0000_0F0F;
    core_lvl   = 8'hF0;
    rd_check("R5 pending low", 9'h04, 32'h0000_0F00);
    rd_check("R5 pending high", 9'h08, 32'hAAAA_0000);
    rd_check("R6 summary mixed", 9'h00, summary_model(64'hAAAA_0000_0000_0F00, 8'h50));
  endtask

  task automatic t_summary;
    wr(9'h10, 32'hFFFF_FFFF);
    wr(9'h14, 32'hFFFF_FFFF);
    wr(9'h18, 32'h0000_00FF);
    core_lvl = 8'h00;
    periph_lvl = 64'h1 << 7;
    rd_check("R6 source 7", 9'h00, 32'h0000_0500);
    periph_lvl = 64'h1 << 62;
    rd_check("R6 source 62", 9'h00, 32'h0010_0200);
    periph_lvl = 64'h1; core_lvl = 8'h81;
    rd_check("R6 core and bank flag", 9'h00, 32'h0000_0181);
    periph_lvl = '1; core_lvl = 8'hFF;
    rd_check("R6 all active", 9'h00, 32'h001F_FFFF);
    wr(9'h20, 32'h0080_0000);
    rd_check("R6 source 55 disabled", 9'h00, 32'h001D_FFFF);
    wr(9'h14, 32'h0080_0000);
    periph_lvl = 64'h4080_0000_000C_0680; core_lvl = 8'h11;
    rd_check("R6 scattered pattern", 9'h00, summary_model(64'h4080_0000_000C_0680, 8'h11));
  endtask

  task automatic t_irq;
    wr(9'h1C, 32'hFFFF_FFFF);
    wr(9'h20, 32'hFFFF_FFFF);
    wr(9'h24, 32'h0000_00FF);
    wr(9'h18, 32'h0000_0008);
    periph_lvl = '1; core_lvl = 8'h00;
    #1;
    check("R9 irq low without enabled source", 32'(irq_o), 32'h0);
    @(negedge clk);
    core_lvl = 8'h08;
    #1;
    check("R11 R9 irq follows core line same cycle", 32'(irq_o), 32'h1);
    core_lvl = 8'h00;
    periph_lvl = 64'h1 << 40;
    #1;
    check("R9 irq low, source 40 disabled", 32'(irq_o), 32'h0);
    wr(9'h14, 32'h0000_0100);
    check("R11 irq after enable write", 32'(irq_o), 32'h1);
  endtask

  task automatic t_fiq;
    periph_lvl = '0; core_lvl = '0;
    wr(9'h0C, 32'h0000_0085);
    rd_check("R7 fiq control readback", 9'h0C, 32'h0000_0085);
    @(negedge clk);
    periph_lvl = 64'h1 << 5;
    #1;
    check("R8 fiq follows unmasked source 5", 32'(fiq_o), 32'h1);
    check("R9 irq ignores disabled source 5", 32'(irq_o), 32'h0);
    periph_lvl = '0;
    #1;
    check("R8 fiq drops with line", 32'(fiq_o), 32'h0);
    wr(9'h0C, 32'h0000_00C2);
    core_lvl = 8'h04;
    #1;
    check("R8 fiq core index 66", 32'(fiq_o), 32'h1);
    wr(9'h0C, 32'h0000_0042);
    check("R8 fiq disabled", 32'(fiq_o), 32'h0);
    rd_check("R7 fiq control disabled readback", 9'h0C, 32'h0000_0042);
    wr(9'h0C, 32'h0000_00CB);
    periph_lvl = '1; core_lvl = 8'hFF;
    #1;
    check("R8 index 75 selects nothing", 32'(fiq_o), 32'h0);
    wr(9'h0C, 32'h0000_00BF);
    periph_lvl = 64'h1 << 63; core_lvl = 8'h00;
    #1;
    check("R8 index 63", 32'(fiq_o), 32'h1);
    wr(9'h0C, 32'hFFFF_FF85);
    rd_check("R7 upper data bits dropped", 9'h0C, 32'h0000_0085);
    periph_lvl = '0;
  endtask

  task automatic t_unmapped;
    rd_check("R10 read 0x28", 9'h028, 32'h0);
    rd_check("R10 read 0x1FC", 9'h1FC, 32'h0);
    rd_check("R10 read unaligned 0x12", 9'h012, 32'h0);
    wr(9'h004, 32'hFFFF_FFFF);
    wr(9'h000, 32'hFFFF_FFFF);
    wr(9'h028, 32'hFFFF_FFFF);
    wr(9'h012, 32'hFFFF_FFFF);
    wr(9'h00D, 32'hFFFF_FFFF);
    rd_check("R10 low enables kept", 9'h10, 32'h0);
    rd_check("R10 high enables kept", 9'h14, 32'h0000_0100);
    rd_check("R10 core enables kept", 9'h18, 32'h0000_0008);
    rd_check("R10 fiq control kept", 9'h0C, 32'h0000_0085);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_set();
    t_clear();
    t_core();
    t_pending();
    t_summary();
    t_irq();
    t_fiq();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule